// File: doc/BRIEF.md
# TDM Command and Audio Frame Receiver

This block is the receiving end of a serial link that carries control commands and audio samples in one time-division-multiplexed frame. It runs on the link's bit clock and sees three inputs: a frame-start strobe, the bit clock itself and a serial data line. It works out from the width of the frame-start strobe whether the link is running in TDM mode. It then splits each frame into 32-bit fields and executes the register writes and reads that are addressed to its device number or to the broadcast number. It also pulls its own left and right samples out of the audio slots.

Register read data leave on a serial output with a separate output-enable. A pad wrapper turns that pair into a three-state pin. The enable rises one bit early so the pin has time to leave high impedance. The device number and the audio slot position are inputs, because the chain logic that assigns them lives elsewhere. Audio pairs leave through a valid/ready port. The link cannot be stalled, so back-pressure has limited power. A pair stays offered until it is taken, and a newer pair that arrives before then replaces it.

Top module: `tdmcf_rx`

## Requirements
- R1: TDM mode is set only by frame-start pulses that stay high for exactly two bit-clock samples. A pulse seen high for a third sample, or for only one sample, clears the mode at once. `tdm_mode` reports the mode.
- R2: The mode turns on after two qualifying frames in a row. Frames start being honoured (writes, reads, audio) with the next frame. A frame that begins outside TDM mode has no effect.
- R3: A frame's first field begins with the bit sampled on the rising edge where the frame strobe is first seen high. Each field is 32 bits, MSB first. Bits 7:0 of every field are ignored.
- R4: Command field layout, from bit 31 down: bit 31 ID-assignment flag, bit 30 extension flag, bit 29 chain select, bits 28:24 device number, bit 23 direction (1 = read), bits 22:16 register number, bits 15:8 data. A write stores the data byte when chain select is 0 and the device number equals `dev_id`.
- R5: Device number 31 writes to every device but never starts a read. Device number 0 selects nobody.
- R6: When bit 31 of the command field is 1, the whole frame has no effect: no write, no read, no audio.
- R7: When the extension flag is set, the fields that follow are extended commands with the same layout, with bit 31 ignored. The chain continues while each extended field has bit 30 set. Fields after the chain has ended are ignored. Such a frame carries no audio.
- R8: On a read hit, data bits 7..0 of the addressed register appear on `sdo` in the slots of field bits 15..8, changing on falling edges. `sdo_oe` rises one bit earlier, in the bit-16 slot, with `sdo` at 0. It is low at all other times.
- R9: A command with chain select = 1 is ignored.
- R10: Audio slot k is field k+1 of a frame. The left sample is taken from slot `aud_slot` and the right from slot `aud_slot`+1. Each sample is field bits 31:8. The pair is offered once the right field is complete.
- R11: `aud_valid` stays high with the data unchanged until `aud_ready` is sampled high. A newer pair arriving before acceptance replaces the held one.
- R12: Register numbers at or above NREG are not written, and reads of them return 0. All registers reset to 0.
- R13: After reset `tdm_mode`, `sdo_oe` and `aud_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs | input | 1 | Frame-start strobe |
| sdi | input | 1 | Serial command/audio input, sampled on rising edge |
| dev_id | input | 5 | This device's number in the chain |
| aud_slot | input | 5 | Audio slot holding this device's left sample |
| sdo | output | 1 | Serial read data, changes on falling edge |
| sdo_oe | output | 1 | Drive enable for the serial output pad |
| tdm_mode | output | 1 | TDM mode detected |
| aud_valid | output | 1 | Audio pair offered |
| aud_ready | input | 1 | Audio pair accepted when high with valid |
| aud_left | output | 24 | Left sample |
| aud_right | output | 24 | Right sample |

## Verification
A write takes effect on the rising edge that captures the field's last bit. Read bits and the output enable change on the falling edge before the slot in which the host samples them. So the bench records `sdo` and `sdo_oe` 2 ns after each falling edge, per field and per bit, and compares whole slot patterns after the frame. Audio pairs and the mode flag are due one edge after the completing bit. The bench waits for the rising edge that ends the frame and checks them 1 ns later, before the next frame starts.

// File: rtl/tdmcf_pkg.sv
package tdmcf_pkg;
  localparam int FIELD_BITS = 32;
  localparam int POS_W      = $clog2(FIELD_BITS);
  localparam int FIDX_W     = 6;
  localparam logic [4:0] ID_BCAST = 5'h1F;
  localparam logic [4:0] ID_NONE  = 5'h00;
  // bit-slot numbers counted from the field's first (MSB) bit
  localparam logic [POS_W-1:0] POS_HDR_LAST = 5'd8;
  localparam logic [POS_W-1:0] POS_REG_LAST = 5'd15;
  localparam logic [POS_W-1:0] POS_RD_FIRST = 5'd16;
  localparam logic [POS_W-1:0] POS_RD_LAST  = 5'd23;

  typedef struct packed {
    logic       did;
    logic       emd;
    logic       dcs;
    logic [4:0] id;
    logic       rd;
    logic [6:0] regn;
    logic [7:0] data;
    logic [7:0] pad;
  } tdm_cmd_t;
endpackage

// File: rtl/tdmcf_mode_det.sv
module tdmcf_mode_det (
  input  logic bck,
  input  logic rst_n,
  input  logic fs,
  output logic fs_rise,
  output logic tdm_mode,
  output logic frame_ok
);
  logic       fs_d;
  logic [1:0] hi_cnt;
  logic [1:0] q_cnt;

  assign fs_rise = fs & ~fs_d;

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) begin
      fs_d     <= 1'b0;
      hi_cnt   <= '0;
      q_cnt    <= '0;
      tdm_mode <= 1'b0;
      frame_ok <= 1'b0;
    end else begin
      fs_d <= fs;
      if (fs_rise) begin
        hi_cnt   <= 2'd1;
        frame_ok <= tdm_mode;
      end else if (fs && hi_cnt != 2'd3) begin
        hi_cnt <= hi_cnt + 2'd1;
      end
      if (fs && !fs_rise && hi_cnt == 2'd2) begin
        q_cnt    <= '0;
        tdm_mode <= 1'b0;
        frame_ok <= 1'b0;
      end else if (!fs && fs_d) begin
        if (hi_cnt == 2'd2) begin
          q_cnt <= (q_cnt == 2'd2) ? 2'd2 : q_cnt + 2'd1;
          if (q_cnt != 2'd0) tdm_mode <= 1'b1;
        end else begin
          q_cnt    <= '0;
          tdm_mode <= 1'b0;
          frame_ok <= 1'b0;
        end
      end
    end
  end

  AST_MODE_RISE_PULSE: assert property (@(posedge bck) disable iff (!rst_n)
    $rose(tdm_mode) |-> (!$past(fs) && $past(fs, 2) && $past(fs, 3) && !$past(fs, 4))); // R1
  AST_FRAME_NEEDS_MODE: assert property (@(posedge bck) disable iff (!rst_n)
    $rose(frame_ok) |-> $past(tdm_mode)); // R2
endmodule

// File: rtl/tdmcf_field_rx.sv
module tdmcf_field_rx
  import tdmcf_pkg::*;
(
  input  logic                  bck,
  input  logic                  rst_n,
  input  logic                  fs_rise,
  input  logic                  sdi,
  output logic [POS_W-1:0]      nxt,
  output logic [FIDX_W-1:0]     fidx,
  output logic [FIELD_BITS-1:0] sr,
  output logic [FIELD_BITS-1:0] word,
  output logic                  field_done
);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(FIELD_BITS - 1);
  localparam logic [FIDX_W-1:0] FIDX_IDLE = '1;

  assign word       = {sr[FIELD_BITS-2:0], sdi};
  assign field_done = (nxt == POS_LAST) && !fs_rise;

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      nxt  <= '0;
      fidx <= FIDX_IDLE;
    end else if (fs_rise) begin
      sr   <= {{(FIELD_BITS-1){1'b0}}, sdi};
      nxt  <= POS_W'(1);
      fidx <= '0;
    end else begin
      sr  <= word;
      nxt <= nxt + POS_W'(1);
      if (nxt == POS_LAST && fidx != FIDX_IDLE) fidx <= fidx + FIDX_W'(1);
    end
  end
endmodule

// File: rtl/tdmcf_cmd.sv
module tdmcf_cmd
  import tdmcf_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic                  bck,
  input  logic                  rst_n,
  input  logic                  frame_ok,
  input  logic                  fs_rise,
  input  logic                  sdi,
  input  logic                  field_done,
  input  logic [POS_W-1:0]      nxt,
  input  logic [FIDX_W-1:0]     fidx,
  input  logic [FIELD_BITS-1:0] sr,
  input  logic [FIELD_BITS-1:0] word,
  input  logic [4:0]            dev_id,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic                  audio_ok
);
  localparam int IDX_W = $clog2(NREG);

  tdm_cmd_t   c;
  logic       emd_live, did_f, emd_f, rd_hit;
  logic       id_ok, is_cmd, wr_hit, hdr_hit;
  logic [8:0] hdr;
  logic [6:0] rd_reg;
  logic [7:0] regs [NREG];
  logic [7:0] rdata;
  logic [4:0] rd_pos;

  assign c        = tdm_cmd_t'(word);
  assign id_ok    = (dev_id != ID_NONE) && (dev_id != ID_BCAST);
  assign is_cmd   = (fidx == '0) ? !c.did : emd_live;
  assign wr_hit   = frame_ok && field_done && is_cmd && !c.dcs && !c.rd &&
                    ((c.id == dev_id && id_ok) || c.id == ID_BCAST) &&
                    (int'(c.regn) < NREG);
  // header bits of the field in flight: did, emd, dcs, id[4:0], rd
  assign hdr      = {sr[7:0], sdi};
  assign hdr_hit  = frame_ok && ((fidx == '0) ? !hdr[8] : emd_live) &&
                    !hdr[6] && hdr[0] && hdr[5:1] == dev_id && id_ok;
  assign audio_ok = frame_ok && !did_f && !emd_f;
  assign rdata    = (int'(rd_reg) < NREG) ? regs[rd_reg[IDX_W-1:0]] : 8'h00;
  assign rd_pos   = POS_RD_LAST - nxt;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge bck or negedge rst_n) begin
      if (!rst_n) regs[g] <= 8'h00;
      else if (wr_hit && c.regn[IDX_W-1:0] == IDX_W'(g)) regs[g] <= c.data;
    end
  end

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) begin
      emd_live <= 1'b0;
      did_f    <= 1'b0;
      emd_f    <= 1'b0;
      rd_hit   <= 1'b0;
      rd_reg   <= '0;
    end else if (fs_rise) begin
      emd_live <= 1'b0;
      did_f    <= 1'b0;
      emd_f    <= 1'b0;
      rd_hit   <= 1'b0;
    end else begin
      if (field_done) begin
        rd_hit <= 1'b0;
        if (fidx == '0) begin
          did_f    <= c.did;
          emd_f    <= c.emd && !c.did;
          emd_live <= c.emd && !c.did;
        end else if (emd_live) begin
          emd_live <= c.emd;
        end
      end else if (nxt == POS_HDR_LAST) begin
        rd_hit <= hdr_hit;
      end
      if (nxt == POS_REG_LAST) rd_reg <= {sr[5:0], sdi};
    end
  end

  always_ff @(negedge bck or negedge rst_n) begin
    if (!rst_n) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (rd_hit && nxt == POS_REG_LAST) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b1;
    end else if (rd_hit && nxt >= POS_RD_FIRST && nxt <= POS_RD_LAST) begin
      sdo    <= rdata[rd_pos[2:0]];
      sdo_oe <= 1'b1;
    end else begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end
  end

  AST_OE_WINDOW: assert property (@(posedge bck) disable iff (!rst_n)
    sdo_oe |-> (nxt >= POS_REG_LAST && nxt <= POS_RD_LAST)); // R8
  AST_OE_FRAME_OK: assert property (@(posedge bck) disable iff (!rst_n)
    sdo_oe |-> frame_ok); // R2
endmodule

// File: rtl/tdmcf_rx.sv
module tdmcf_rx
  import tdmcf_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic        bck,
  input  logic        rst_n,
  input  logic        fs,
  input  logic        sdi,
  input  logic [4:0]  dev_id,
  input  logic [4:0]  aud_slot,
  output logic        sdo,
  output logic        sdo_oe,
  output logic        tdm_mode,
  output logic        aud_valid,
  input  logic        aud_ready,
  output logic [23:0] aud_left,
  output logic [23:0] aud_right
);
  logic                  fs_rise, frame_ok, field_done, audio_ok;
  logic [POS_W-1:0]      nxt;
  logic [FIDX_W-1:0]     fidx, fidx_l, fidx_r;
  logic [FIELD_BITS-1:0] sr, word;
  logic [23:0]           l_hold;
  logic                  l_have;

  tdmcf_mode_det u_mode (
    .bck(bck), .rst_n(rst_n), .fs(fs),
    .fs_rise(fs_rise), .tdm_mode(tdm_mode), .frame_ok(frame_ok)
  );

  tdmcf_field_rx u_field (
    .bck(bck), .rst_n(rst_n), .fs_rise(fs_rise), .sdi(sdi),
    .nxt(nxt), .fidx(fidx), .sr(sr), .word(word), .field_done(field_done)
  );

  tdmcf_cmd #(.NREG(NREG)) u_cmd (
    .bck(bck), .rst_n(rst_n), .frame_ok(frame_ok), .fs_rise(fs_rise),
    .sdi(sdi), .field_done(field_done), .nxt(nxt), .fidx(fidx),
    .sr(sr), .word(word), .dev_id(dev_id),
    .sdo(sdo), .sdo_oe(sdo_oe), .audio_ok(audio_ok)
  );

  // audio slot k sits in field k+1
  assign fidx_l = FIDX_W'(aud_slot) + FIDX_W'(1);
  assign fidx_r = FIDX_W'(aud_slot) + FIDX_W'(2);

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) begin
      l_hold    <= '0;
      l_have    <= 1'b0;
      aud_valid <= 1'b0;
      aud_left  <= '0;
      aud_right <= '0;
    end else begin
      if (fs_rise) l_have <= 1'b0;
      else if (field_done && audio_ok && fidx == fidx_l) begin
        l_hold <= word[31:8];
        l_have <= 1'b1;
      end
      if (field_done && audio_ok && fidx == fidx_r && l_have) begin
        aud_left  <= l_hold;
        aud_right <= word[31:8];
        aud_valid <= 1'b1;
      end else if (aud_valid && aud_ready) begin
        aud_valid <= 1'b0;
      end
    end
  end

  AST_AUD_HOLD: assert property (@(posedge bck) disable iff (!rst_n)
    (aud_valid && !aud_ready) |=> aud_valid); // R11
  AST_AUD_NEEDS_FRAME: assert property (@(posedge bck) disable iff (!rst_n)
    $rose(aud_valid) |-> $past(frame_ok)); // R10
endmodule

// File: tb/sim_tdmcf_rx.sv
module sim_tdmcf_rx;
  logic bck = 1'b0;
  always #5 bck = ~bck;

  logic        rst_n, fs, sdi, aud_ready;
  logic [4:0]  dev_id, aud_slot;
  logic        sdo, sdo_oe, tdm_mode, aud_valid;
  logic [23:0] aud_left, aud_right;

  tdmcf_rx #(.NREG(16)) u0 (
    .bck(bck), .rst_n(rst_n), .fs(fs), .sdi(sdi), .dev_id(dev_id),
    .aud_slot(aud_slot), .sdo(sdo), .sdo_oe(sdo_oe), .tdm_mode(tdm_mode),
    .aud_valid(aud_valid), .aud_ready(aud_ready),
    .aud_left(aud_left), .aud_right(aud_right)
  );

  localparam logic [31:0] OE_PAT = 32'h00FF8000; // slots 15..23
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] fw [8];
  logic [31:0] oe_v [8];
  logic [31:0] sd_v [8];
  logic [7:0]  model [32];

  function automatic logic [31:0] cmdw(bit did, bit emd, bit dcs, logic [4:0] id,
                                       bit rd, logic [6:0] rn, logic [7:0] d);
    return {did, emd, dcs, id, rd, rn, d, 8'($urandom)};
  endfunction

  function automatic logic [7:0] rd_byte(int f);
    logic [7:0] b = '0;
    for (int i = 16; i <= 23; i++) b = {b[6:0], sd_v[f][i]};
    return b;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr;
    for (int f = 0; f < 8; f++) fw[f] = '0;
  endtask

  task automatic send_frame(int fsw, bit pop);
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < 32; i++) begin
        @(negedge bck);
        fs        = (f * 32 + i) < fsw;
        sdi       = fw[f][31-i];
        aud_ready = pop && f == 0 && i == 0;
        #2;
        oe_v[f][i] = sdo_oe;
        sd_v[f][i] = sdo;
      end
    end
    @(posedge bck);
    #1;
  endtask

  task automatic chk_read(int f, logic [7:0] exp, string tag);
    chk(oe_v[f] == OE_PAT, {tag, " oe"}, 64'(oe_v[f]), 64'(OE_PAT));
    chk(rd_byte(f) == exp, {tag, " data"}, 64'(rd_byte(f)), 64'(exp));
  endtask

  task automatic chk_quiet(int f, string tag);
    chk(oe_v[f] == 32'h0, {tag, " no drive"}, 64'(oe_v[f]), 64'h0);
  endtask

  task automatic chk_aud(logic [31:0] l, logic [31:0] r, string tag);
    chk(aud_valid === 1'b1, {tag, " valid"}, 64'(aud_valid), 64'h1);
    chk({aud_left, aud_right} == {l[31:8], r[31:8]}, {tag, " pair"},
        64'({aud_left, aud_right}), 64'({l[31:8], r[31:8]}));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] la, ra, lb, rb;
    logic [6:0]  rn;
    logic [7:0]  d;
    logic [4:0]  wid;
    void'($urandom(32'd4711));
    for (int k = 0; k < 32; k++) model[k] = 8'h00;
    rst_n = 0; fs = 0; sdi = 0; aud_ready = 0; dev_id = 5'd5; aud_slot = 5'd1;
    repeat (4) @(posedge bck);
    #1;
    chk(!tdm_mode && !sdo_oe && !aud_valid, "R13 reset", 64'({tdm_mode, sdo_oe, aud_valid}), 64'h0);
    @(negedge bck);
    rst_n = 1;

    // R2: two qualifying frames, commands and audio in them ignored
    clr; fw[0] = cmdw(0, 0, 0, 5'd5, 0, 7'd3, 8'hAA);
    fw[2] = 32'h11223344; fw[3] = 32'h55667788;
    send_frame(2, 0);
    chk(tdm_mode == 1'b0, "R2 one frame no mode", 64'(tdm_mode), 64'h0);
    send_frame(2, 0);
    chk(tdm_mode == 1'b1, "R1 mode after two frames", 64'(tdm_mode), 64'h1);
    chk(aud_valid == 1'b0, "R2 audio ignored before mode", 64'(aud_valid), 64'h0);

    // third frame honoured: read reg3 (write earlier was ignored), audio
    clr; fw[0] = cmdw(0, 0, 0, 5'd5, 1, 7'd3, 8'h00);
    la = 32'hA1B2C3FF; ra = 32'hD4E5F6EE; fw[2] = la; fw[3] = ra; fw[1] = 32'h99999999;
    send_frame(2, 0);
    chk_read(0, 8'h00, "R2 early write dropped");
    chk_aud(la, ra, "R10 first pair");

    // R7: extension chain; write reg3, ext read reg3, ext write reg6, ended chain writes reg7
    clr; fw[0] = cmdw(0, 1, 0, 5'd5, 0, 7'd3, 8'hA5);
    fw[1] = cmdw(1, 1, 0, 5'd5, 1, 7'd3, 8'h00);
    fw[2] = cmdw(0, 0, 0, 5'd5, 0, 7'd6, 8'h77);
    fw[3] = cmdw(0, 0, 0, 5'd5, 0, 7'd7, 8'h11);
    send_frame(2, 0);
    model[3] = 8'hA5; model[6] = 8'h77;
    chk_read(1, 8'hA5, "R7 ext read after write");
    chk_quiet(0, "R8 write field");
    chk_aud(la, ra, "R7 no audio in ext frame R11 held");

    // pop old pair, new pair arrives; read reg6
    clr; fw[0] = cmdw(0, 0, 0, 5'd5, 1, 7'd6, 8'h00);
    lb = 32'h0F0E0D00; rb = 32'h0C0B0A01; fw[2] = lb; fw[3] = rb;
    send_frame(2, 1);
    chk_read(0, 8'h77, "R7 ext write in chain");
    chk_aud(lb, rb, "R11 new pair after accept");
    // replacement without accept
    clr; la = 32'h12345600; ra = 32'h789ABC00; fw[2] = la; fw[3] = ra;
    send_frame(2, 0);
    chk_aud(la, ra, "R11 newer pair replaces");

    // R6: ID-assignment frame, consumes pending pair, no new one
    clr; fw[0] = cmdw(1, 0, 0, 5'd5, 0, 7'd8, 8'h5A); fw[2] = 32'hFFFFFF00; fw[3] = 32'hEEEEEE00;
    send_frame(2, 1);
    chk(aud_valid == 1'b0, "R6 no audio in id frame", 64'(aud_valid), 64'h0);

    // broadcast, id 0, other id, chain select, out of range
    clr; fw[0] = cmdw(0, 1, 0, 5'd31, 0, 7'd9, 8'h3C);
    fw[1] = cmdw(0, 1, 0, 5'd0, 0, 7'd10, 8'h44);
    fw[2] = cmdw(0, 1, 0, 5'd6, 0, 7'd11, 8'h55);
    fw[3] = cmdw(0, 1, 1, 5'd5, 0, 7'd12, 8'h66);
    fw[4] = cmdw(0, 0, 0, 5'd5, 0, 7'd20, 8'h77);
    send_frame(2, 0);
    model[9] = 8'h3C;
    clr; fw[0] = cmdw(0, 1, 0, 5'd5, 1, 7'd9, 8'h00);
    fw[1] = cmdw(0, 1, 0, 5'd5, 1, 7'd8, 8'h00);
    fw[2] = cmdw(0, 1, 0, 5'd5, 1, 7'd10, 8'h00);
    fw[3] = cmdw(0, 1, 0, 5'd5, 1, 7'd11, 8'h00);
    fw[4] = cmdw(0, 1, 0, 5'd5, 1, 7'd12, 8'h00);
    fw[5] = cmdw(0, 1, 0, 5'd5, 1, 7'd20, 8'h00);
    fw[6] = cmdw(0, 1, 0, 5'd31, 1, 7'd9, 8'h00);
    fw[7] = cmdw(0, 0, 1, 5'd5, 1, 7'd9, 8'h00);
    send_frame(2, 0);
    chk_read(0, 8'h3C, "R5 broadcast write");
    chk_read(1, 8'h00, "R6 id frame write dropped");
    chk_read(2, 8'h00, "R5 id zero write dropped");
    chk_read(3, 8'h00, "R4 other id write dropped");
    chk_read(4, 8'h00, "R9 chain select write dropped");
    chk_read(5, 8'h00, "R12 out of range reads zero");
    chk_quiet(6, "R5 broadcast read");
    chk_quiet(7, "R9 chain select read");

    // R1: long strobe drops mode, then two frames needed again
    clr; fw[0] = cmdw(0, 0, 0, 5'd5, 0, 7'd2, 8'h01);
    send_frame(128, 0);
    chk(tdm_mode == 1'b0, "R1 wide strobe clears mode", 64'(tdm_mode), 64'h0);
    clr; fw[0] = cmdw(0, 0, 0, 5'd5, 1, 7'd3, 8'h00);
    send_frame(2, 0);
    chk_quiet(0, "R2 read outside mode");
    chk(tdm_mode == 1'b0, "R2 one frame after drop", 64'(tdm_mode), 64'h0);
    send_frame(1, 0);
    chk(tdm_mode == 1'b0, "R1 short strobe", 64'(tdm_mode), 64'h0);
    send_frame(2, 0);
    send_frame(2, 0);
    chk(tdm_mode == 1'b1, "R1 mode regained", 64'(tdm_mode), 64'h1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      clr;
      if (it % 2 == 0) begin
        rn = 7'($urandom_range(0, 19));
        d = 8'($urandom);
        case ($urandom_range(0, 3))
          0: wid = 5'd5;
          1: wid = 5'd31;
          2: wid = 5'd6;
          default: wid = 5'd0;
        endcase
        fw[0] = cmdw(0, 1, 0, wid, 0, rn, d);
        fw[1] = cmdw(0, 0, 0, 5'd5, 1, rn, 8'h00);
        fw[2] = 32'($urandom);
        send_frame(2, 1);
        if (rn < 16 && (wid == 5'd5 || wid == 5'd31)) model[rn[4:0]] = d;
        chk_read(1, (rn < 16) ? model[rn[4:0]] : 8'h00, "R4 random write/read");
        chk(aud_valid == 1'b0, "R7 random ext frame no audio", 64'(aud_valid), 64'h0);
      end else begin
        aud_slot = 5'($urandom_range(0, 5));
        rn = 7'($urandom_range(0, 15));
        fw[0] = cmdw(0, 0, 0, 5'd5, 1, rn, 8'h00);
        for (int f = 1; f < 8; f++) fw[f] = 32'($urandom);
        send_frame(2, 1);
        chk_read(0, model[rn[4:0]], "R3 random read");
        chk_aud(fw[aud_slot + 1], fw[aud_slot + 2], "R10 random slot");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule